// File: doc/BRIEF.md
# Buffered SPI Master with Serial-Port Status Flags

This block is an SPI master whose software view follows the habits of an asynchronous serial port rather than a bare shift-done bit. A byte written to the data address first lands in a one-entry holding register. It moves into the shift engine as soon as the engine is free, so software can queue the next byte while the current one is still on the wire. Each byte leaves MSB first on the output data line while the input line is sampled into a receive shifter. The completed byte is placed in a single receive buffer.

Three flags describe the state of the block. Receive-complete means an unread byte is waiting. Transmit-complete means the shifter and the holding register have both drained. Data-register-empty means a new byte may be written. Each flag drives its own interrupt line through an enable bit. Transmit-complete can be cleared either by an acknowledge pulse from the interrupt controller or by software. A control register holds the enables. A divider register sets the serial clock rate. No UART error status ever appears.

Top module: `bspi_master`

## Requirements
- R1: After reset, the status read (address 1) is 8'h26: receive-complete 0, transmit-complete 0, data-register-empty 1, low bits 5'b00110. Control and divider read 0. SPI clock, SPI data out and all three interrupt lines are low.
- R2: A write to address 0 is taken only while the transmit enable (control bit 3) is 1 and data-register-empty (status bit 5) is 1. Data-register-empty then reads 0. If the shifter is idle, the byte moves into it on the next clock and data-register-empty reads 1 again. If the shifter is busy, the byte waits and data-register-empty stays 0 until the frame ends. Writes at any other time are ignored.
- R3: A frame lasts 8 SPI clock periods, each of 2*(D+1) system clocks, where D is the divider register (address 3). The SPI clock idles low and is low for the first half of each period. The data out line carries the byte MSB first and changes only on falling edges. Its first bit is present from the load. The input line is sampled on each rising edge. Data out is low while idle.
- R4: Transmit-complete (status bit 6) sets on the clock that ends a frame, but only if the holding register is empty and no byte is being accepted in that cycle. If a byte is pending, the next frame starts one clock later and the flag does not set.
- R5: Transmit-complete clears on a tc_ack pulse or on a status write with bit 6 set. A status write with bit 6 clear leaves it unchanged. A set in the same cycle wins over a clear.
- R6: While the receive enable (control bit 4) is 1, the eighth rising SPI clock edge of a frame writes the received byte into the receive buffer and sets receive-complete (status bit 7). Reading address 0 returns the buffer and clears receive-complete. A new byte overwrites an unread one and raises no error.
- R7: While the receive enable is 0, the receive buffer is held at 0 and receive-complete at 0, so clearing the enable flushes any unread byte. Bytes received in that state are discarded.
- R8: Status bits 4:0 always read 5'b00110, whatever is written to the status address. No frame, parity or overrun indication exists.
- R9: Control bits 7, 6 and 5 enable the receive-complete, transmit-complete and data-register-empty interrupts. Each interrupt line is its flag ANDed with its enable. Control reads back with bits 2:0 as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 data, 1 status, 2 control, 3 divider |
| bus_wdata | input | 8 | Write data |
| tc_ack | input | 1 | Transmit-complete interrupt acknowledge pulse |
| spi_miso | input | 1 | Serial data in |
| bus_rdata | output | 8 | Read data for the register selected by bus_addr |
| irq_rxc | output | 1 | Receive-complete interrupt |
| irq_txc | output | 1 | Transmit-complete interrupt |
| irq_dre | output | 1 | Data-register-empty interrupt |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |

## Verification
The hardest case to reach is the back-to-back frame. A second byte has to be written during the first frame's short window, after the first byte has left the holding register and before the frame ends. A third write then has to arrive while the holding register is full, so that it is dropped and transmit-complete stays clear at the first frame end. The stimulus times these writes a few clocks after the first load and repeats the pattern at several divider settings. The overwrite of an unread receive byte and the flush on receive disable are reached by running frames without reading, then turning the receive enable off with receive-complete still set.

// File: rtl/bspi_pkg.sv
package bspi_pkg;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  localparam int S_RXC = 7;
  localparam int S_TXC = 6;
  localparam int S_DRE = 5;

  localparam logic [4:0] STAT_FIXED = 5'b00110;

  typedef struct packed {
    logic ie_rx;
    logic ie_tx;
    logic ie_dre;
    logic rx_en;
    logic tx_en;
  } ctrl_t;
endpackage

// File: rtl/bspi_rstsync.sv
module bspi_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/bspi_clkgen.sv
module bspi_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (start || !run || tick) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/bspi_shift.sv
module bspi_shift #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              rx_done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              frame_end
);
  logic              busy_q, busy_d;
  logic              sck_q, sck_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] tx_q, tx_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              last_bit;

  assign last_bit  = (bit_q == CNT_W'(DATA_W-1));
  assign rx_byte   = {rx_q[DATA_W-2:0], miso};
  assign rx_done   = tick && !sck_q && last_bit;
  assign frame_end = tick && sck_q && last_bit;
  assign busy      = busy_q;
  assign sck       = sck_q;
  assign mosi      = busy_q && tx_q[DATA_W-1];

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (load) begin
      busy_d = 1'b1;
      sck_d  = 1'b0;
      bit_d  = '0;
      tx_d   = load_byte;
    end else if (tick) begin
      sck_d = !sck_q;
      if (!sck_q) begin
        rx_d = rx_byte;
      end else if (last_bit) begin
        busy_d = 1'b0;
      end else begin
        bit_d = bit_q + 1'b1;
        tx_d  = {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);
  // R3
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(sck));
  // R3
  mosi_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load && !(tick && sck)) |=> $stable(mosi));
endmodule

// File: rtl/bspi_regs.sv
module bspi_regs
  import bspi_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tc_ack,
  input  logic              busy,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              frame_end,
  output logic [DATA_W-1:0] rdata,
  output logic              load,
  output logic [DATA_W-1:0] load_byte,
  output logic [DIV_W-1:0]  div,
  output logic              irq_rxc,
  output logic              irq_txc,
  output logic              irq_dre
);
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              full_q, full_d;
  logic [DATA_W-1:0] rxbuf_q, rxbuf_d;
  logic              rxc_q, rxc_d;
  logic              txc_q, txc_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              wr_acc, rd_data, wr_ok, dre;

  assign wr_acc    = sel && wr;
  assign rd_data   = sel && !wr && (addr == A_DATA);
  assign wr_ok     = wr_acc && (addr == A_DATA) && ctrl_q.tx_en && !full_q;
  assign load      = full_q && ctrl_q.tx_en && !busy;
  assign load_byte = hold_q;
  assign div       = div_q;
  assign dre       = !full_q;

  assign irq_rxc = rxc_q && ctrl_q.ie_rx;
  assign irq_txc = txc_q && ctrl_q.ie_tx;
  assign irq_dre = dre   && ctrl_q.ie_dre;

  always_comb begin
    unique case (addr)
      A_DATA:  rdata = rxbuf_q;
      A_STAT:  rdata = {rxc_q, txc_q, dre, STAT_FIXED};
      A_CTRL:  rdata = {ctrl_q, 3'b000};
      default: rdata = DATA_W'(div_q);
    endcase
  end

  always_comb begin
    hold_d  = hold_q;
    full_d  = full_q;
    rxbuf_d = rxbuf_q;
    rxc_d   = rxc_q;
    txc_d   = txc_q;
    ctrl_d  = ctrl_q;
    div_d   = div_q;

    if (load) full_d = 1'b0;
    if (wr_ok) begin
      full_d = 1'b1;
      hold_d = wdata;
    end

    if (frame_end && !full_q && !wr_ok)
      txc_d = 1'b1;
    else if (tc_ack || (wr_acc && addr == A_STAT && wdata[S_TXC]))
      txc_d = 1'b0;

    if (!ctrl_q.rx_en) begin
      rxc_d   = 1'b0;
      rxbuf_d = '0;
    end else if (rx_done) begin
      rxc_d   = 1'b1;
      rxbuf_d = rx_byte;
    end else if (rd_data) begin
      rxc_d = 1'b0;
    end

    if (wr_acc && addr == A_CTRL) ctrl_d = ctrl_t'(wdata[7:3]);
    if (wr_acc && addr == A_DIV)  div_d  = wdata[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      full_q  <= 1'b0;
      rxbuf_q <= '0;
      rxc_q   <= 1'b0;
      txc_q   <= 1'b0;
      ctrl_q  <= '0;
      div_q   <= '0;
    end else begin
      hold_q  <= hold_d;
      full_q  <= full_d;
      rxbuf_q <= rxbuf_d;
      rxc_q   <= rxc_d;
      txc_q   <= txc_d;
      ctrl_q  <= ctrl_d;
      div_q   <= div_d;
    end
  end

  // R2
  dre_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !busy) |=> !dre ##1 dre);
  // R4
  txc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txc_q) |-> (dre && !busy));
  // R6
  rxc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && ctrl_q.rx_en) |=> rxc_q);
  // R7
  rx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.rx_en |=> !rxc_q);
endmodule

// File: rtl/bspi_master.sv
module bspi_master #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       tc_ack,
  input  logic       spi_miso,
  output logic [7:0] bus_rdata,
  output logic       irq_rxc,
  output logic       irq_txc,
  output logic       irq_dre,
  output logic       spi_sck,
  output logic       spi_mosi
);
  localparam int DATA_W = 8;

  logic              srst_n;
  logic              load, busy, tick, rx_done, frame_end;
  logic [DATA_W-1:0] load_byte, rx_byte;
  logic [DIV_W-1:0]  div;

  bspi_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  bspi_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(srst_n),
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .tc_ack(tc_ack), .busy(busy), .rx_done(rx_done), .rx_byte(rx_byte),
    .frame_end(frame_end), .rdata(bus_rdata), .load(load),
    .load_byte(load_byte), .div(div),
    .irq_rxc(irq_rxc), .irq_txc(irq_txc), .irq_dre(irq_dre)
  );

  bspi_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(srst_n), .run(busy), .start(load), .div(div),
    .tick(tick)
  );

  bspi_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(srst_n), .load(load), .load_byte(load_byte),
    .tick(tick), .miso(spi_miso), .busy(busy), .sck(spi_sck),
    .mosi(spi_mosi), .rx_done(rx_done), .rx_byte(rx_byte),
    .frame_end(frame_end)
  );
endmodule

// File: tb/sim_bspi_master.sv
module sim_bspi_master;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, ack = 1'b0, miso = 1'b0;
  logic [1:0] addr = 2'd1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq_rxc, irq_txc, irq_dre, sck, mosi;

  bspi_master u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .tc_ack(ack), .spi_miso(miso), .bus_rdata(rdata),
    .irq_rxc(irq_rxc), .irq_txc(irq_txc), .irq_dre(irq_dre),
    .spi_sck(sck), .spi_mosi(mosi)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit cmp_on = 0, done = 0;

  // behavioural reference state
  int       m_rc = 0, m_t = 0;
  bit       m_busy = 0, m_full = 0, m_txc = 0, m_rxc = 0;
  logic [7:0] m_hold = 0, m_cur = 0, m_rxsh = 0, m_rxbuf = 0, m_ctrl = 0, m_div = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= lfsr[0];
  end

  always @(posedge clk) begin : model
    bit fe, rdone, ld, hf0, wrok, wacc;
    int h, m;
    if (!rst_n || m_rc < 2) begin
      if (!rst_n) m_rc = 0; else m_rc++;
      m_busy = 0; m_full = 0; m_txc = 0; m_rxc = 0; m_t = 0;
      m_hold = 0; m_cur = 0; m_rxbuf = 0; m_ctrl = 0; m_div = 0;
    end else begin
      fe = 0; rdone = 0; ld = 0; hf0 = m_full;
      wacc = sel && wr;
      wrok = wacc && addr == 2'd0 && m_ctrl[3] && !m_full;
      h = int'(m_div) + 1;
      if (m_busy) begin
        m_t++;
        if (m_t % h == 0) begin
          m = m_t / h;
          if (m % 2 == 1) m_rxsh = {m_rxsh[6:0], miso};
          if (m == 15) rdone = 1;
          if (m == 16) begin m_busy = 0; fe = 1; end
        end
      end else if (m_full && m_ctrl[3]) begin
        ld = 1; m_busy = 1; m_t = 0; m_cur = m_hold;
      end
      if (ld) m_full = 0;
      if (wrok) begin m_full = 1; m_hold = wdata; end
      if (fe && !hf0 && !wrok) m_txc = 1;
      else if (ack || (wacc && addr == 2'd1 && wdata[6])) m_txc = 0;
      if (!m_ctrl[4]) begin m_rxc = 0; m_rxbuf = 0; end
      else if (rdone) begin m_rxc = 1; m_rxbuf = m_rxsh; end
      else if (sel && !wr && addr == 2'd0) m_rxc = 0;
      if (wacc && addr == 2'd2) m_ctrl = wdata & 8'hF8;
      if (wacc && addr == 2'd3) m_div = wdata;
    end
  end

  always @(negedge clk) begin
    logic [7:0] st, er;
    int h, bi;
    if (cmp_on) begin
      h  = int'(m_div) + 1;
      bi = m_busy ? (m_t / (2*h)) : 0;
      st = {m_rxc, m_txc, !m_full, 5'b00110};
      chk("R3 sck", {7'd0, sck}, {7'd0, m_busy && ((m_t / h) % 2 == 1)});
      chk("R3 mosi", {7'd0, mosi}, {7'd0, m_busy && m_cur[7-bi]});
      case (addr)
        2'd0: begin er = m_rxbuf; chk("R6 data", rdata, er); end
        2'd1: begin er = st; chk("R2/R4/R6/R8 status", rdata, er); end
        2'd2: begin er = m_ctrl; chk("R9 ctrl", rdata, er); end
        default: begin er = m_div; chk("R3 div", rdata, er); end
      endcase
      chk("R9 irq_rxc", {7'd0, irq_rxc}, {7'd0, m_rxc && m_ctrl[7]});
      chk("R9 irq_txc", {7'd0, irq_txc}, {7'd0, m_txc && m_ctrl[6]});
      chk("R9 irq_dre", {7'd0, irq_dre}, {7'd0, !m_full && m_ctrl[5]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  task automatic bw(logic [1:0] a, logic [7:0] d);
    @(posedge clk); #1;
    sel = 1; wr = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 0; wr = 0; addr = 2'd1;
  endtask

  task automatic br(logic [1:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    sel = 1; wr = 0; addr = a;
    @(negedge clk); d = rdata;
    @(posedge clk); #1;
    sel = 0; addr = 2'd1;
  endtask

  task automatic wait_idle();
    forever begin
      @(posedge clk); #2;
      if (!m_busy && !m_full) break;
    end
    repeat (3) @(posedge clk);
  endtask

  task automatic pulse_ack();
    @(posedge clk); #1 ack = 1;
    @(posedge clk); #1 ack = 0;
  endtask

  task automatic burst(logic [7:0] a, logic [7:0] b);
    bw(2'd0, a);
    repeat (2) @(posedge clk);
    bw(2'd0, b);
    bw(2'd0, 8'h77);  // R2: holding full, dropped
    wait_idle();
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    cmp_on = 1;
    @(negedge clk);
    chk("R1 status in reset", rdata, 8'h26);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 status after reset", rdata, 8'h26);
    chk("R1 sck", {7'd0, sck}, 8'd0);
    br(2'd2, d); chk("R1 ctrl", d, 8'h00);
    br(2'd3, d); chk("R1 div", d, 8'h00);

    // R9 enables, R2/R3 chained frames at several dividers
    bw(2'd2, 8'hF8);
    burst(8'hA5, 8'h3C);
    br(2'd1, d); chk("R4 txc after chain", d & 8'h40, 8'h40);
    br(2'd0, d);
    br(2'd1, d); chk("R6 rxc cleared by read", d & 8'h80, 8'h00);

    // R5 clear paths
    bw(2'd1, 8'h00);
    br(2'd1, d); chk("R5 write zero keeps txc", d & 8'h40, 8'h40);
    bw(2'd1, 8'h40);
    br(2'd1, d); chk("R5 write one clears txc", d & 8'h40, 8'h00);
    bw(2'd3, 8'd3);
    burst(8'h5A, 8'hC3);
    pulse_ack();
    br(2'd1, d); chk("R5 ack clears txc", d & 8'h40, 8'h00);

    // R8 reserved bits
    bw(2'd1, 8'hFF);
    br(2'd1, d); chk("R8 low bits fixed", d & 8'h1F, 8'h06);

    // R6 overwrite, R7 flush
    bw(2'd3, 8'd1);
    bw(2'd0, 8'h81); wait_idle();
    bw(2'd0, 8'h18); wait_idle();
    br(2'd1, d); chk("R6 rxc held through overwrite", d & 8'h80, 8'h80);
    bw(2'd2, 8'hE8);
    br(2'd0, d); chk("R7 buffer flushed", d, 8'h00);
    br(2'd1, d); chk("R7 rxc flushed", d & 8'h80, 8'h00);
    bw(2'd0, 8'hF0); wait_idle();
    br(2'd1, d); chk("R7 rx ignored while off", d & 8'h80, 8'h00);

    // R2 write ignored while transmitter off
    bw(2'd2, 8'hB0);
    bw(2'd0, 8'h11);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R2 no frame when tx off", {7'd0, sck}, 8'd0);
    br(2'd1, d); chk("R2 dre stays set", d & 8'h20, 8'h20);

    bw(2'd2, 8'hF8);
    bw(2'd3, 8'd7);
    burst(8'h96, 8'h69);
    bw(2'd3, 8'd0);
    burst(8'hFF, 8'h00);
    repeat (5) @(posedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule